// File: doc/BRIEF.md
# Issue Queue with Register Wakeup

This block holds renamed instructions of an out-of-order core while they wait for their physical source registers. Each entry keeps a sequence number, an execution route and a ready bit for each of up to two source tags. A per-register scoreboard records which physical registers already hold results. Entries raise a per-entry ready flag once both sources are available. An external selector picks among the ready entries and returns the chosen index on the issue port.

Completion broadcasts carry a destination tag. They wake every waiting source with that tag and set the register's scoreboard bit. Each insert re-checks its not-ready sources against the scoreboard and against a broadcast in the same cycle, so a wakeup that occurred while the instruction was in flight is not lost. A squash carries a sequence-number boundary and removes younger waiting entries. A free-entry count tells the front end how much room is left.

Top module: `issue_queue`

## Requirements
- R1: After reset no entry is valid, `free_cnt_o` equals DEPTH, `ins_err_o` is 0, and every scoreboard bit is not-ready, so an inserted source that rename marked not-ready stays not-ready until a broadcast.
- R2: An accepted insert writes the lowest-index free entry, which is valid from the next cycle, and lowers `free_cnt_o` by one.
- R3: An insert while `free_cnt_o` is 0 changes no entry, and `ins_err_o` is 1 in the following cycle only.
- R4: An inserted source marked not-ready whose scoreboard bit is set is ready in the entry from the next cycle.
- R5: An insert with an in-range destination tag clears that register's scoreboard bit, so a later insert naming it as a not-ready source waits.
- R6: Tags at or above NUM_INT_PREGS+NUM_FP_PREGS never block readiness and never change the scoreboard.
- R7: A broadcast with an in-range tag marks that source ready in every valid entry waiting on it from the next cycle and sets its scoreboard bit; `ready_o[i]` is 1 exactly when entry i is valid and both its sources are ready.
- R8: A broadcast in the same cycle as an insert whose source names the broadcast tag leaves the new entry's source ready.
- R9: The route code of an entry follows the kind bits (bit 0 control, bit 1 memory, bit 2 integer, bit 3 floating-point) in that priority: control 0, memory 1, integer 2, floating-point 3, none set gives miscellaneous 4; `route_o[3*i +: 3]` carries entry i.
- R10: A squash frees every valid entry whose sequence number is greater, as an unsigned value, than the boundary, keeps the rest, and does not touch an insert of the same cycle.
- R11: An issue of a valid entry frees it; an issue naming a free entry has no effect.
- R12: `free_cnt_o` always equals DEPTH minus the number of valid entries and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert request |
| ins_seq_i | input | SEQ_W | Sequence number of the inserted instruction |
| ins_kind_i | input | 4 | Kind bits: 0 control, 1 memory, 2 integer, 3 floating-point |
| ins_src0_tag_i | input | TAG_W | First source physical tag |
| ins_src0_rdy_i | input | 1 | First source ready at rename |
| ins_src1_tag_i | input | TAG_W | Second source physical tag |
| ins_src1_rdy_i | input | 1 | Second source ready at rename |
| ins_dst_tag_i | input | TAG_W | Destination physical tag |
| wk_valid_i | input | 1 | Completion broadcast valid |
| wk_tag_i | input | TAG_W | Destination tag of the completed instruction |
| sq_valid_i | input | 1 | Squash request |
| sq_seq_i | input | SEQ_W | Squash boundary; younger entries are removed |
| iss_valid_i | input | 1 | Issue notification |
| iss_idx_i | input | $clog2(DEPTH) | Index of the issued entry |
| valid_o | output | DEPTH | Entry occupied |
| ready_o | output | DEPTH | Entry valid with both sources ready |
| route_o | output | 3*DEPTH | Route code per entry |
| free_cnt_o | output | $clog2(DEPTH+1) | Number of free entries |
| ins_err_o | output | 1 | Insert was rejected in the previous cycle |

## Verification
Directed sequences separate the paths by which a source can become ready: rename-ready, scoreboard hit at insert, a broadcast after insert, a broadcast in the very cycle of insert, and an out-of-range tag. A destination that re-arms a register shows that the scoreboard clears as well as sets. Filling the queue, overflowing it and then squashing at two boundaries, one together with an insert, checks allocation order, rejection and age-based removal. A long mixed run with overlapping inserts, broadcasts, issues and squashes is compared every cycle against a behavioural model, and exposes ordering errors between a clear and a set in one cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int ROUTE_W = 3;
  localparam int KIND_W  = 4;

  typedef enum logic [ROUTE_W-1:0] {
    RT_CTRL = 3'd0,
    RT_MEM  = 3'd1,
    RT_INT  = 3'd2,
    RT_FP   = 3'd3,
    RT_MISC = 3'd4
  } route_e;

  // fixed priority: control, memory, integer, floating-point, misc
  function automatic logic [ROUTE_W-1:0] pick_route(logic [KIND_W-1:0] kind);
    route_e r;
    if (kind[0])      r = RT_CTRL;
    else if (kind[1]) r = RT_MEM;
    else if (kind[2]) r = RT_INT;
    else if (kind[3]) r = RT_FP;
    else              r = RT_MISC;
    return r;
  endfunction
endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard #(
  parameter int NUM_PREGS = 32,
  parameter int TAG_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_vld_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             clr_vld_i,
  input  logic [TAG_W-1:0] clr_tag_i,
  input  logic [TAG_W-1:0] q0_tag_i,
  input  logic [TAG_W-1:0] q1_tag_i,
  output logic             q0_rdy_o,
  output logic             q1_rdy_o
);
  localparam int PREG_W = $clog2(NUM_PREGS);
  localparam logic [TAG_W-1:0] LIM = TAG_W'(NUM_PREGS);

  logic [NUM_PREGS-1:0] sb_q;

  logic set_in, clr_in;
  assign set_in = set_vld_i && (set_tag_i < LIM);
  assign clr_in = clr_vld_i && (clr_tag_i < LIM);

  for (genvar p = 0; p < NUM_PREGS; p++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sb_q[p] <= 1'b0;
      end else if (clr_in && clr_tag_i[PREG_W-1:0] == PREG_W'(p)) begin
        sb_q[p] <= 1'b0;  // new producer wins over same-cycle completion
      end else if (set_in && set_tag_i[PREG_W-1:0] == PREG_W'(p)) begin
        sb_q[p] <= 1'b1;
      end
    end
  end

  // lookup with bypass of a broadcast in the same cycle
  assign q0_rdy_o = !(q0_tag_i < LIM) || sb_q[q0_tag_i[PREG_W-1:0]]
                    || (set_vld_i && set_tag_i == q0_tag_i);
  assign q1_rdy_o = !(q1_tag_i < LIM) || sb_q[q1_tag_i[PREG_W-1:0]]
                    || (set_vld_i && set_tag_i == q1_tag_i);
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEPTH-1:0] valid_i,
  input  logic             req_i,
  input  logic [DEPTH-1:0] freed_i,
  output logic [DEPTH-1:0] grant_o,
  output logic             ok_o,
  output logic             err_o,
  output logic [CNT_W-1:0] free_cnt_o
);
  logic [DEPTH-1:0] first;
  logic             any_free;
  logic [CNT_W-1:0] n_freed;
  logic [CNT_W-1:0] free_q;
  logic             err_q;

  always_comb begin
    first    = '0;
    any_free = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid_i[i] && !any_free) begin
        first[i] = 1'b1;
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    n_freed = '0;
    for (int i = 0; i < DEPTH; i++) n_freed = n_freed + CNT_W'(freed_i[i]);
  end

  assign ok_o    = req_i && any_free;
  assign grant_o = first & {DEPTH{ok_o}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= CNT_W'(DEPTH);
      err_q  <= 1'b0;
    end else begin
      free_q <= free_q - CNT_W'(ok_o) + n_freed;
      err_q  <= req_i && !any_free;
    end
  end

  assign free_cnt_o = free_q;
  assign err_o      = err_q;
endmodule

// File: rtl/iq_entry.sv
module iq_entry #(
  parameter int SEQ_W = 16,
  parameter int TAG_W = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_i,
  input  logic [SEQ_W-1:0]           seq_i,
  input  logic [iq_pkg::ROUTE_W-1:0] route_i,
  input  logic [TAG_W-1:0]           s0_tag_i,
  input  logic                       s0_rdy_i,
  input  logic [TAG_W-1:0]           s1_tag_i,
  input  logic                       s1_rdy_i,
  input  logic                       wk_vld_i,
  input  logic [TAG_W-1:0]           wk_tag_i,
  input  logic                       iss_i,
  input  logic                       sq_vld_i,
  input  logic [SEQ_W-1:0]           sq_seq_i,
  output logic                       valid_o,
  output logic                       ready_o,
  output logic [iq_pkg::ROUTE_W-1:0] route_o,
  output logic                       freed_o
);
  logic                       valid_q, r0_q, r1_q;
  logic [SEQ_W-1:0]           seq_q;
  logic [TAG_W-1:0]           t0_q, t1_q;
  logic [iq_pkg::ROUTE_W-1:0] route_q;
  logic                       kill;

  assign kill = valid_q && (iss_i || (sq_vld_i && (seq_q > sq_seq_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      r0_q    <= 1'b0;
      r1_q    <= 1'b0;
      seq_q   <= '0;
      t0_q    <= '0;
      t1_q    <= '0;
      route_q <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      seq_q   <= seq_i;
      route_q <= route_i;
      t0_q    <= s0_tag_i;
      t1_q    <= s1_tag_i;
      r0_q    <= s0_rdy_i;
      r1_q    <= s1_rdy_i;
    end else if (kill) begin
      valid_q <= 1'b0;
    end else if (valid_q && wk_vld_i) begin
      if (wk_tag_i == t0_q) r0_q <= 1'b1;
      if (wk_tag_i == t1_q) r1_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q && r0_q && r1_q;
  assign route_o = route_q;
  assign freed_o = kill;
endmodule

// File: rtl/issue_queue.sv
module issue_queue
  import iq_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int NUM_INT_PREGS = 16,
  parameter int NUM_FP_PREGS  = 16,
  parameter int TAG_W        = 6,
  parameter int SEQ_W        = 16,
  localparam int NUM_PREGS   = NUM_INT_PREGS + NUM_FP_PREGS,
  localparam int IDX_W       = $clog2(DEPTH),
  localparam int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ins_valid_i,
  input  logic [SEQ_W-1:0]           ins_seq_i,
  input  logic [KIND_W-1:0]          ins_kind_i,
  input  logic [TAG_W-1:0]           ins_src0_tag_i,
  input  logic                       ins_src0_rdy_i,
  input  logic [TAG_W-1:0]           ins_src1_tag_i,
  input  logic                       ins_src1_rdy_i,
  input  logic [TAG_W-1:0]           ins_dst_tag_i,
  input  logic                       wk_valid_i,
  input  logic [TAG_W-1:0]           wk_tag_i,
  input  logic                       sq_valid_i,
  input  logic [SEQ_W-1:0]           sq_seq_i,
  input  logic                       iss_valid_i,
  input  logic [IDX_W-1:0]           iss_idx_i,
  output logic [DEPTH-1:0]           valid_o,
  output logic [DEPTH-1:0]           ready_o,
  output logic [ROUTE_W*DEPTH-1:0]   route_o,
  output logic [CNT_W-1:0]           free_cnt_o,
  output logic                       ins_err_o
);
  logic [DEPTH-1:0]   grant, freed;
  logic               ins_ok;
  logic               sb0_rdy, sb1_rdy;
  logic               s0_rdy, s1_rdy;
  logic [ROUTE_W-1:0] ins_route;

  iq_alloc #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_alloc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_o),
    .req_i      (ins_valid_i),
    .freed_i    (freed),
    .grant_o    (grant),
    .ok_o       (ins_ok),
    .err_o      (ins_err_o),
    .free_cnt_o (free_cnt_o)
  );

  iq_scoreboard #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_vld_i (wk_valid_i),
    .set_tag_i (wk_tag_i),
    .clr_vld_i (ins_ok),
    .clr_tag_i (ins_dst_tag_i),
    .q0_tag_i  (ins_src0_tag_i),
    .q1_tag_i  (ins_src1_tag_i),
    .q0_rdy_o  (sb0_rdy),
    .q1_rdy_o  (sb1_rdy)
  );

  assign s0_rdy    = ins_src0_rdy_i || sb0_rdy;
  assign s1_rdy    = ins_src1_rdy_i || sb1_rdy;
  assign ins_route = pick_route(ins_kind_i);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    iq_entry #(.SEQ_W(SEQ_W), .TAG_W(TAG_W)) u_ent (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .alloc_i  (grant[i]),
      .seq_i    (ins_seq_i),
      .route_i  (ins_route),
      .s0_tag_i (ins_src0_tag_i),
      .s0_rdy_i (s0_rdy),
      .s1_tag_i (ins_src1_tag_i),
      .s1_rdy_i (s1_rdy),
      .wk_vld_i (wk_valid_i),
      .wk_tag_i (wk_tag_i),
      .iss_i    (iss_valid_i && iss_idx_i == IDX_W'(i)),
      .sq_vld_i (sq_valid_i),
      .sq_seq_i (sq_seq_i),
      .valid_o  (valid_o[i]),
      .ready_o  (ready_o[i]),
      .route_o  (route_o[i*ROUTE_W +: ROUTE_W]),
      .freed_o  (freed[i])
    );
  end
endmodule

// File: rtl/issue_queue_chk.sv
module issue_queue_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ins_valid_i,
  input logic             sq_valid_i,
  input logic             iss_valid_i,
  input logic [IDX_W-1:0] iss_idx_i,
  input logic [DEPTH-1:0] valid_o,
  input logic [DEPTH-1:0] ready_o,
  input logic [CNT_W-1:0] free_cnt_o,
  input logic             ins_err_o
);
  assert_free_match_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt_o == CNT_W'(DEPTH - $countones(valid_o)));

  assert_no_overflow_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt_o <= CNT_W'(DEPTH));

  assert_err_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_err_o |-> ($past(ins_valid_i) && $past(free_cnt_o) == '0));

  assert_full_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && free_cnt_o == '0 && !iss_valid_i && !sq_valid_i) |=> $stable(valid_o));

  assert_insert_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && free_cnt_o != '0 && !iss_valid_i && !sq_valid_i)
      |=> free_cnt_o == $past(free_cnt_o) - 1'b1);

  assert_ready_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o & ~valid_o) == '0);

  assert_issue_frees_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i && valid_o[iss_idx_i] && !ins_valid_i) |=> !valid_o[$past(iss_idx_i)]);
endmodule

bind issue_queue issue_queue_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ins_valid_i (ins_valid_i),
  .sq_valid_i  (sq_valid_i),
  .iss_valid_i (iss_valid_i),
  .iss_idx_i   (iss_idx_i),
  .valid_o     (valid_o),
  .ready_o     (ready_o),
  .free_cnt_o  (free_cnt_o),
  .ins_err_o   (ins_err_o)
);

// File: tb/tb_issue_queue.sv
`timescale 1ns/1ps
module tb_issue_queue;
  localparam int DEPTH = 8;
  localparam int NPR   = 32;
  localparam int TAG_W = 6;
  localparam int SEQ_W = 16;
  localparam int IDX_W = 3;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             ins_valid, s0_rdy, s1_rdy, wk_valid, sq_valid, iss_valid;
  logic [SEQ_W-1:0] ins_seq, sq_seq;
  logic [3:0]       ins_kind;
  logic [TAG_W-1:0] s0_tag, s1_tag, dst_tag, wk_tag;
  logic [IDX_W-1:0] iss_idx;
  logic [DEPTH-1:0] valid_o, ready_o;
  logic [3*DEPTH-1:0] route_o;
  logic [CNT_W-1:0] free_cnt;
  logic             ins_err;

  issue_queue #(.DEPTH(DEPTH), .NUM_INT_PREGS(16), .NUM_FP_PREGS(16),
                .TAG_W(TAG_W), .SEQ_W(SEQ_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(ins_valid), .ins_seq_i(ins_seq), .ins_kind_i(ins_kind),
    .ins_src0_tag_i(s0_tag), .ins_src0_rdy_i(s0_rdy),
    .ins_src1_tag_i(s1_tag), .ins_src1_rdy_i(s1_rdy),
    .ins_dst_tag_i(dst_tag), .wk_valid_i(wk_valid), .wk_tag_i(wk_tag),
    .sq_valid_i(sq_valid), .sq_seq_i(sq_seq),
    .iss_valid_i(iss_valid), .iss_idx_i(iss_idx),
    .valid_o(valid_o), .ready_o(ready_o), .route_o(route_o),
    .free_cnt_o(free_cnt), .ins_err_o(ins_err)
  );

  int n_vec = 0;
  int n_bad = 0;

  // behavioural reference
  bit m_v[DEPTH];
  bit m_r0[DEPTH];
  bit m_r1[DEPTH];
  int m_seq[DEPTH];
  int m_t0[DEPTH];
  int m_t1[DEPTH];
  int m_rt[DEPTH];
  bit m_sb[NPR];
  int m_free;
  bit m_err;

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int route_of(logic [3:0] k);
    if (k[0]) return 0;
    if (k[1]) return 1;
    if (k[2]) return 2;
    if (k[3]) return 3;
    return 4;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 0; m_r0[i] = 0; m_r1[i] = 0;
    end
    for (int p = 0; p < NPR; p++) m_sb[p] = 0;
    m_free = DEPTH;
    m_err = 0;
  endtask

  task automatic model_step();
    int slot;
    int nfree;
    bit kill;
    bit r0, r1;
    slot = -1;
    for (int i = DEPTH - 1; i >= 0; i--) if (!m_v[i]) slot = i;
    r0 = s0_rdy || (int'(s0_tag) >= NPR) || (int'(s0_tag) < NPR && m_sb[s0_tag])
         || (wk_valid && wk_tag == s0_tag);
    r1 = s1_rdy || (int'(s1_tag) >= NPR) || (int'(s1_tag) < NPR && m_sb[s1_tag])
         || (wk_valid && wk_tag == s1_tag);
    for (int i = 0; i < DEPTH; i++) begin
      if (m_v[i]) begin
        kill = (iss_valid && int'(iss_idx) == i) || (sq_valid && m_seq[i] > int'(sq_seq));
        if (kill) begin
          m_v[i] = 0;
          m_free++;
        end else if (wk_valid) begin
          if (int'(wk_tag) == m_t0[i]) m_r0[i] = 1;
          if (int'(wk_tag) == m_t1[i]) m_r1[i] = 1;
        end
      end
    end
    m_err = ins_valid && slot < 0;
    if (wk_valid && int'(wk_tag) < NPR) m_sb[wk_tag] = 1;
    if (ins_valid && slot >= 0) begin
      m_v[slot] = 1; m_seq[slot] = int'(ins_seq);
      m_t0[slot] = int'(s0_tag); m_t1[slot] = int'(s1_tag);
      m_r0[slot] = r0; m_r1[slot] = r1;
      m_rt[slot] = route_of(ins_kind);
      m_free--;
      if (int'(dst_tag) < NPR) m_sb[dst_tag] = 0;
    end
    nfree = m_free;
    m_free = nfree;
  endtask

  task automatic compare();
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 valid", int'(valid_o[i]), int'(m_v[i]));
      chk("R7 ready", int'(ready_o[i]), int'(m_v[i] && m_r0[i] && m_r1[i]));
      if (m_v[i]) chk("R9 route", int'(route_o[3*i +: 3]), m_rt[i]);
    end
    chk("R12 free", int'(free_cnt), m_free);
    chk("R3 err", int'(ins_err), int'(m_err));
  endtask

  task automatic idle();
    ins_valid = 0; wk_valid = 0; sq_valid = 0; iss_valid = 0;
    s0_rdy = 0; s1_rdy = 0;
  endtask

  task automatic step();
    model_step();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic put(int seq, logic [3:0] kind, int t0, int t1, int dst);
    ins_valid = 1; ins_seq = SEQ_W'(seq); ins_kind = kind;
    s0_tag = TAG_W'(t0); s1_tag = TAG_W'(t1); dst_tag = TAG_W'(dst);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int seqc;
    idle();
    ins_seq = '0; ins_kind = '0; s0_tag = '0; s1_tag = '0; dst_tag = '0;
    wk_tag = '0; sq_seq = '0; iss_idx = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare();
    chk("R1 free", int'(free_cnt), 8);
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 err", int'(ins_err), 0);

    put(1, 4'b0001, 3, 40, 5); step();
    chk("R1 scoreboard starts not-ready", int'(ready_o[0]), 0);
    chk("R2 lowest slot", int'(valid_o), 8'h01);
    wk_valid = 1; wk_tag = 3; step();
    chk("R7 wake", int'(ready_o[0]), 1);
    put(2, 4'b0100, 3, 41, 6); step();
    chk("R4 recheck at insert", int'(ready_o[1]), 1);
    put(3, 4'b0100, 40, 41, 3); step();
    chk("R6 out-of-range sources", int'(ready_o[2]), 1);
    put(4, 4'b1000, 3, 40, 7); step();
    chk("R5 dest clears", int'(ready_o[3]), 0);
    put(5, 4'b0000, 7, 40, 8); wk_valid = 1; wk_tag = 7; step();
    chk("R8 same-cycle wake", int'(ready_o[4]), 1);
    iss_valid = 1; iss_idx = 0; step();
    chk("R11 issue frees", int'(valid_o), 8'h1E);
    chk("R11 free count", int'(free_cnt), 4);
    iss_valid = 1; iss_idx = 0; step();
    chk("R11 empty issue ignored", int'(valid_o), 8'h1E);
    chk("R11 empty issue count", int'(free_cnt), 4);
    put(6, 4'b0110, 40, 40, 45); step();
    chk("R2 refill lowest", int'(valid_o), 8'h1F);
    chk("R9 memory over integer", int'(route_o[2:0]), 1);
    put(7, 4'b0000, 40, 40, 45); step();
    chk("R9 misc", int'(route_o[17:15]), 4);
    put(8, 4'b1100, 40, 40, 45); step();
    chk("R9 integer over fp", int'(route_o[20:18]), 2);
    put(9, 4'b1000, 40, 40, 45); step();
    chk("R9 fp", int'(route_o[23:21]), 3);
    chk("R12 full", int'(free_cnt), 0);
    put(10, 4'b0001, 40, 40, 45); step();
    chk("R3 reject flag", int'(ins_err), 1);
    chk("R3 reject no change", int'(valid_o), 8'hFF);
    step();
    chk("R3 flag one cycle", int'(ins_err), 0);
    sq_valid = 1; sq_seq = 6; step();
    chk("R10 squash younger", int'(valid_o), 8'h1F);
    chk("R10 squash count", int'(free_cnt), 3);
    sq_valid = 1; sq_seq = 2; put(11, 4'b0010, 40, 40, 45); step();
    chk("R10 squash with insert", int'(valid_o), 8'h22);
    chk("R10 squash with insert count", int'(free_cnt), 6);

    seqc = 20;
    for (int c = 0; c < 5000; c++) begin
      if ($urandom_range(0, 9) < 6) begin
        seqc++;
        put(seqc, 4'($urandom_range(0, 15)), $urandom_range(0, 39),
            $urandom_range(0, 39), $urandom_range(0, 39));
        s0_rdy = ($urandom_range(0, 3) == 0);
        s1_rdy = ($urandom_range(0, 3) == 0);
      end
      if ($urandom_range(0, 1) == 1) begin
        wk_valid = 1; wk_tag = TAG_W'($urandom_range(0, 39));
      end
      if ($urandom_range(0, 9) < 4) begin
        iss_valid = 1; iss_idx = IDX_W'($urandom_range(0, DEPTH - 1));
      end
      if ($urandom_range(0, 49) < 2) begin
        sq_valid = 1; sq_seq = SEQ_W'(seqc - $urandom_range(0, 8));
      end
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule